// File: doc/BRIEF.md
# Serial XON/XOFF Transmit Injector

This block sits in front of a UART serializer and places software flow-control characters into the outgoing character stream. It watches the fill level of the local receive FIFO. When the level climbs above a programmable halt threshold, it sends a short burst of "stop" characters to the remote sender. Once the level has drained back to a lower resume threshold, it sends a burst of "go" characters. The gap between the two thresholds gives hysteresis, so the block does not toggle back and forth around one level.

Ordinary transmit data arrives from the TX FIFO over a valid/data/ready handshake. The injector merges that data with the flow characters and drives a single valid/data/ready stream to the serializer through one output register. A pending flow burst takes priority over FIFO data, but only once the character already offered to the serializer has been accepted. A held-off flag records that a stop burst has gone out. While the flag is set, no further stop burst is sent. If transmit flow control is switched off while the flag is set, a go burst is sent automatically.

Top module: `xonxoff_tx_inject`

## Requirements
- R1: `tx_mode` selects the flow characters. Bit 1 enables the first character set (`xon_a`/`xoff_a`) and bit 0 enables the second set (`xon_b`/`xoff_b`). 2'b10 gives a burst `a,a`. 2'b01 gives a burst `b,b`. 2'b11 gives a burst `a,b,a,b`, in which each first character is immediately followed by its partner.
- R2: With `tx_mode` not 2'b00 and the flag clear, a receive level strictly greater than 4×`halt_trig` starts a stop burst of `xoff_*` characters. A level equal to 4×`halt_trig` starts nothing.
- R3: With the flag set, a receive level at or below 4×`resume_trig` starts a go burst of `xon_*` characters and clears the flag. A level one above 4×`resume_trig` starts nothing.
- R4: While the flag is set, no second stop burst is sent, however long the level stays above the halt threshold.
- R5: With `tx_mode` = 2'b00 and the flag clear, no flow character is ever sent. If `tx_mode` becomes 2'b00 while the flag is set, a go burst is sent automatically, using the mode that was in force when the stop burst was sent.
- R6: Every character offered on `chr_data` keeps only its low 5+`word_len` bits. `word_len` 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. All upper bits are zero. This applies to flow characters and FIFO data alike.
- R7: A pending flow burst is emitted before any further FIFO data. `fifo_ready` is low for as long as a burst is pending. A character already offered is completed first. FIFO bytes keep their order.
- R8: While `chr_valid` is high and `chr_ready` is low, `chr_valid` stays high and `chr_data` does not change.
- R9: After reset, `chr_valid` is low, `fifo_ready` is high and the held-off flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_level | input | 7 | Current receive FIFO fill level (0..64) |
| halt_trig | input | 4 | Halt threshold, in units of 4 entries |
| resume_trig | input | 4 | Resume threshold, in units of 4 entries |
| tx_mode | input | 2 | Transmit flow-control mode |
| xon_a | input | 8 | First go character |
| xon_b | input | 8 | Second go character |
| xoff_a | input | 8 | First stop character |
| xoff_b | input | 8 | Second stop character |
| word_len | input | 2 | Character length code (5 + value bits) |
| fifo_valid | input | 1 | TX FIFO has a byte |
| fifo_data | input | 8 | TX FIFO byte |
| fifo_ready | output | 1 | TX FIFO byte is taken this cycle |
| chr_valid | output | 1 | Character offered to serializer |
| chr_data | output | 8 | Character to serializer |
| chr_ready | input | 1 | Serializer accepts the character |

## Verification
The bench sweeps every enabled mode against every word length. In each case it steps the receive level to exactly the halt threshold and then one past it, and to one above the resume threshold and then exactly onto it. An off-by-one comparison would send a burst one entry early or late, and a wrong mask would leak upper bits. It keeps the level high after a stop burst, where a design without the held-off flag would send the burst again. It switches the mode to off while the remote side is held, where a design without the latched mode would either stay silent or send the wrong go characters. It stalls the serializer with a data byte already offered and then raises the level. A design that preempts at the wrong point would drop or reorder that byte, or would let FIFO data slip into the middle of the burst.

// File: rtl/xinj_pkg.sv
package xinj_pkg;
  localparam int CHAR_W    = 8;
  localparam int MIN_BITS  = 5;

  typedef enum logic {
    KIND_GO   = 1'b0,
    KIND_STOP = 1'b1
  } flow_kind_e;

  // Mask keeping the low MIN_BITS + wl bits of a character.
  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) begin
      m[i] = (i < MIN_BITS + int'(wl));
    end
    return m;
  endfunction

  // Picks the second character set for a given mode and burst position.
  function automatic logic use_second(input logic [1:0] mode, input logic odd_pos);
    return (mode == 2'b01) || ((mode == 2'b11) && odd_pos);
  endfunction
endpackage

// File: rtl/xinj_level_watch.sv
module xinj_level_watch #(
  parameter int LVL_W      = 7,
  parameter int TRIG_W     = 4,
  parameter int TRIG_SHIFT = 2
) (
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [TRIG_W-1:0] halt_trig,
  input  logic [TRIG_W-1:0] resume_trig,
  output logic              above_halt,
  output logic              at_resume
);
  localparam int TL_W  = TRIG_W + TRIG_SHIFT;
  localparam int CMP_W = (LVL_W > TL_W) ? LVL_W : TL_W;

  logic [CMP_W-1:0] lvl_x;
  logic [CMP_W-1:0] halt_lvl;
  logic [CMP_W-1:0] resume_lvl;

  always_comb begin
    lvl_x      = CMP_W'(rx_level);
    halt_lvl   = CMP_W'(halt_trig) << TRIG_SHIFT;
    resume_lvl = CMP_W'(resume_trig) << TRIG_SHIFT;
    above_halt = lvl_x > halt_lvl;
    at_resume  = lvl_x <= resume_lvl;
  end
endmodule

// File: rtl/xinj_burst_seq.sv
module xinj_burst_seq
  import xinj_pkg::*;
#(
  parameter int REPEAT = 2,
  parameter int IDX_W  = $clog2(2*REPEAT+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tx_mode,
  input  logic              above_halt,
  input  logic              at_resume,
  input  logic              take_flow,
  input  logic [CHAR_W-1:0] xon_a,
  input  logic [CHAR_W-1:0] xon_b,
  input  logic [CHAR_W-1:0] xoff_a,
  input  logic [CHAR_W-1:0] xoff_b,
  output logic              burst_active,
  output logic [CHAR_W-1:0] flow_char,
  output logic              held,
  output logic [IDX_W-1:0]  burst_idx,
  output logic [IDX_W-1:0]  burst_len,
  output logic              start_stop,
  output logic              start_go
);
  flow_kind_e kind_q;
  logic [1:0] bmode_q;
  logic [1:0] held_mode_q;
  logic       last_char;
  logic       second;

  always_comb begin
    start_stop = !burst_active && !held && (tx_mode != 2'b00) && above_halt;
    start_go   = !burst_active && held && ((tx_mode == 2'b00) || at_resume);
    burst_len  = (bmode_q == 2'b11) ? IDX_W'(2*REPEAT) : IDX_W'(REPEAT);
    last_char  = take_flow && (burst_idx == burst_len - IDX_W'(1));
    second     = use_second(bmode_q, burst_idx[0]);
    if (kind_q == KIND_STOP) flow_char = second ? xoff_b : xoff_a;
    else                     flow_char = second ? xon_b  : xon_a;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_active <= 1'b0;
      held         <= 1'b0;
      kind_q       <= KIND_GO;
      bmode_q      <= 2'b00;
      held_mode_q  <= 2'b00;
      burst_idx    <= '0;
    end else if (start_stop) begin
      burst_active <= 1'b1;
      kind_q       <= KIND_STOP;
      bmode_q      <= tx_mode;
      held_mode_q  <= tx_mode;
      held         <= 1'b1;
      burst_idx    <= '0;
    end else if (start_go) begin
      burst_active <= 1'b1;
      kind_q       <= KIND_GO;
      bmode_q      <= held_mode_q;
      held         <= 1'b0;
      burst_idx    <= '0;
    end else if (take_flow) begin
      if (last_char) burst_active <= 1'b0;
      else           burst_idx    <= burst_idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/xinj_out_slot.sv
module xinj_out_slot
  import xinj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burst_active,
  input  logic [CHAR_W-1:0] flow_char,
  input  logic              fifo_valid,
  input  logic [CHAR_W-1:0] fifo_data,
  input  logic [1:0]        word_len,
  input  logic              chr_ready,
  output logic              chr_valid,
  output logic [CHAR_W-1:0] chr_data,
  output logic              fifo_ready,
  output logic              take_flow,
  output logic              take_fifo
);
  logic              slot_free;
  logic [CHAR_W-1:0] mask;

  always_comb begin
    slot_free  = !chr_valid || chr_ready;
    take_flow  = slot_free && burst_active;
    fifo_ready = slot_free && !burst_active;
    take_fifo  = fifo_ready && fifo_valid;
    mask       = len_mask(word_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chr_valid <= 1'b0;
      chr_data  <= '0;
    end else if (take_flow) begin
      chr_valid <= 1'b1;
      chr_data  <= flow_char & mask;
    end else if (take_fifo) begin
      chr_valid <= 1'b1;
      chr_data  <= fifo_data & mask;
    end else if (chr_ready) begin
      chr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xonxoff_tx_inject.sv
module xonxoff_tx_inject
  import xinj_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int TRIG_W     = 4,
  parameter int TRIG_SHIFT = 2,
  parameter int REPEAT     = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rx_level,
  input  logic [TRIG_W-1:0]                 halt_trig,
  input  logic [TRIG_W-1:0]                 resume_trig,
  input  logic [1:0]                        tx_mode,
  input  logic [CHAR_W-1:0]                 xon_a,
  input  logic [CHAR_W-1:0]                 xon_b,
  input  logic [CHAR_W-1:0]                 xoff_a,
  input  logic [CHAR_W-1:0]                 xoff_b,
  input  logic [1:0]                        word_len,
  input  logic                              fifo_valid,
  input  logic [CHAR_W-1:0]                 fifo_data,
  output logic                              fifo_ready,
  output logic                              chr_valid,
  output logic [CHAR_W-1:0]                 chr_data,
  input  logic                              chr_ready
);
  localparam int LVL_W = $clog2(FIFO_DEPTH+1);
  localparam int IDX_W = $clog2(2*REPEAT+1);

  // Named internal events, visible to the bound checker.
  logic              above_halt;
  logic              at_resume;
  logic              burst_active;
  logic [CHAR_W-1:0] flow_char;
  logic              held;
  logic [IDX_W-1:0]  burst_idx;
  logic [IDX_W-1:0]  burst_len;
  logic              start_stop;
  logic              start_go;
  logic              take_flow;
  logic              take_fifo;

  xinj_level_watch #(
    .LVL_W(LVL_W), .TRIG_W(TRIG_W), .TRIG_SHIFT(TRIG_SHIFT)
  ) u_watch (
    .rx_level   (rx_level),
    .halt_trig  (halt_trig),
    .resume_trig(resume_trig),
    .above_halt (above_halt),
    .at_resume  (at_resume)
  );

  xinj_burst_seq #(.REPEAT(REPEAT), .IDX_W(IDX_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_mode     (tx_mode),
    .above_halt  (above_halt),
    .at_resume   (at_resume),
    .take_flow   (take_flow),
    .xon_a       (xon_a),
    .xon_b       (xon_b),
    .xoff_a      (xoff_a),
    .xoff_b      (xoff_b),
    .burst_active(burst_active),
    .flow_char   (flow_char),
    .held        (held),
    .burst_idx   (burst_idx),
    .burst_len   (burst_len),
    .start_stop  (start_stop),
    .start_go    (start_go)
  );

  xinj_out_slot u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_active(burst_active),
    .flow_char   (flow_char),
    .fifo_valid  (fifo_valid),
    .fifo_data   (fifo_data),
    .word_len    (word_len),
    .chr_ready   (chr_ready),
    .chr_valid   (chr_valid),
    .chr_data    (chr_data),
    .fifo_ready  (fifo_ready),
    .take_flow   (take_flow),
    .take_fifo   (take_fifo)
  );
endmodule

// File: rtl/xinj_checks.sv
module xinj_checks #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       tx_mode,
  input logic [1:0]       word_len,
  input logic             held,
  input logic             burst_active,
  input logic [IDX_W-1:0] burst_idx,
  input logic [IDX_W-1:0] burst_len,
  input logic             fifo_ready,
  input logic             chr_valid,
  input logic [7:0]       chr_data,
  input logic             chr_ready
);
  logic [7:0] keep_bits;
  always_comb keep_bits = 8'((9'd1 << (5 + word_len)) - 9'd1);

  assert_burst_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> (burst_idx < burst_len));

  assert_auto_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && (tx_mode == 2'b00) && !burst_active) |=> burst_active);

  assert_upper_bits_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chr_valid |-> ((chr_data & ~keep_bits) == 8'h00));

  assert_fifo_blocked_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_active |-> !fifo_ready);

  assert_offer_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && !chr_ready) |=> (chr_valid && $stable(chr_data)));
endmodule

bind xonxoff_tx_inject xinj_checks #(.IDX_W(IDX_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_mode     (tx_mode),
  .word_len    (word_len),
  .held        (held),
  .burst_active(burst_active),
  .burst_idx   (burst_idx),
  .burst_len   (burst_len),
  .fifo_ready  (fifo_ready),
  .chr_valid   (chr_valid),
  .chr_data    (chr_data),
  .chr_ready   (chr_ready)
);

// File: tb/test_xonxoff_tx_inject.sv
module test_xonxoff_tx_inject;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] GO_A = 8'hF1, GO_B = 8'hB6, STOP_A = 8'hD3, STOP_B = 8'h9C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] rx_level = '0;
  logic [3:0] halt_trig = 4'd8;
  logic [3:0] resume_trig = 4'd2;
  logic [1:0] tx_mode = 2'b00;
  logic [1:0] word_len = 2'd3;
  logic fifo_valid;
  logic [7:0] fifo_data;
  logic fifo_ready;
  logic chr_valid;
  logic [7:0] chr_data;
  logic chr_ready = 1'b1;

  int n_checks = 0;
  int n_fails = 0;

  logic [7:0] q [0:15];
  int q_wr = 0;
  int q_rd = 0;
  logic [7:0] log_mem [0:255];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_valid = q_rd < q_wr;
  assign fifo_data  = q[q_rd[3:0]];

  always @(posedge clk) begin
    if (rst_n && fifo_valid && fifo_ready) q_rd <= q_rd + 1;
    if (rst_n && chr_valid && chr_ready && log_n < 256) begin
      log_mem[log_n] <= chr_data;
      log_n <= log_n + 1;
    end
  end

  xonxoff_tx_inject i_xonxoff_tx_inject (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .halt_trig(halt_trig),
    .resume_trig(resume_trig), .tx_mode(tx_mode), .xon_a(GO_A), .xon_b(GO_B),
    .xoff_a(STOP_A), .xoff_b(STOP_B), .word_len(word_len),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_ready(chr_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(input bit stop, input logic [1:0] mode,
                                          input int pos, input logic [1:0] wl);
    bit b;
    logic [7:0] c;
    b = (mode == 2'b11) ? (pos % 2 == 1) : (mode == 2'b01);
    if (stop) c = b ? STOP_B : STOP_A;
    else      c = b ? GO_B : GO_A;
    return c & (8'hFF >> (3 - wl));
  endfunction

  function automatic int exp_len(input logic [1:0] mode);
    return (mode == 2'b11) ? 4 : 2;
  endfunction

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Compares the characters logged from index base against a burst.
  task automatic chk_burst(input string req, input int base, input bit stop,
                           input logic [1:0] mode, input logic [1:0] wl);
    for (int i = 0; i < exp_len(mode); i++)
      chk(req, {24'h0, log_mem[base+i]}, {24'h0, exp_char(stop, mode, i, wl)});
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 chr_valid", {31'h0, chr_valid}, 0);
    chk("R9 fifo_ready", {31'h0, fifo_ready}, 1);
    rst_n = 1'b1;
    settle(2);
    chk("R9 idle after reset", log_n, 0);

    // R1 R2 R3 R4 R6: sweep modes and word lengths
    for (int m = 1; m < 4; m++) begin
      for (int w = 0; w < 4; w++) begin
        tx_mode  = 2'(m);
        word_len = 2'(w);
        base = log_n;
        rx_level = 7'd32;            // equal to 4*8: no burst
        settle(8);
        chk("R2 at halt level no burst", log_n - base, 0);
        rx_level = 7'd33;
        settle(10);
        chk("R2 stop burst length", log_n - base, exp_len(2'(m)));
        chk_burst("R1 R2 R6 stop chars", base, 1'b1, 2'(m), 2'(w));
        rx_level = 7'd64;
        settle(10);
        chk("R4 no repeated stop burst", log_n - base, exp_len(2'(m)));
        base = log_n;
        rx_level = 7'd9;             // one above 4*2
        settle(8);
        chk("R3 above resume no burst", log_n - base, 0);
        rx_level = 7'd8;
        settle(10);
        chk("R3 go burst length", log_n - base, exp_len(2'(m)));
        chk_burst("R1 R3 R6 go chars", base, 1'b0, 2'(m), 2'(w));
        rx_level = 7'd0;
        settle(2);
      end
    end

    // R5: mode off sends nothing
    tx_mode = 2'b00; word_len = 2'd3;
    base = log_n;
    rx_level = 7'd64;
    settle(12);
    chk("R5 off mode silent", log_n - base, 0);
    rx_level = 7'd0;
    settle(2);

    // R5: turning off while held sends go burst with the latched mode
    tx_mode = 2'b11;
    base = log_n;
    rx_level = 7'd50;
    settle(10);
    chk("R5 stop burst before off", log_n - base, 4);
    base = log_n;
    tx_mode = 2'b00;
    settle(10);
    chk("R5 auto go length", log_n - base, 4);
    chk_burst("R5 auto go chars", base, 1'b0, 2'b11, 2'd3);
    settle(10);
    chk("R5 no retrigger while off", log_n - base, 4);
    rx_level = 7'd0;
    settle(2);

    // R7 R8: data offered first, burst waits, FIFO blocked
    tx_mode = 2'b10; word_len = 2'd2;
    chr_ready = 1'b0;
    q[0] = 8'hDA; q[1] = 8'h35; q[2] = 8'hC7;
    q_wr = 3;
    settle(2);
    rx_level = 7'd40;
    settle(2);
    chk("R8 offered data held", {31'h0, chr_valid}, 1);
    chk("R8 offered data value", {24'h0, chr_data}, 32'h5A);
    chk("R7 fifo blocked while burst pending", {31'h0, fifo_ready}, 0);
    settle(3);
    chk("R8 data stable under stall", {24'h0, chr_data}, 32'h5A);
    base = log_n;
    chr_ready = 1'b1;
    settle(12);
    chk("R7 count", log_n - base, 5);
    chk("R7 first is data", {24'h0, log_mem[base]}, 32'h5A);
    chk("R7 stop 1", {24'h0, log_mem[base+1]}, {24'h0, exp_char(1'b1, 2'b10, 0, 2'd2)});
    chk("R7 stop 2", {24'h0, log_mem[base+2]}, {24'h0, exp_char(1'b1, 2'b10, 1, 2'd2)});
    chk("R7 data order 1", {24'h0, log_mem[base+3]}, 32'h35);
    chk("R7 data order 2", {24'h0, log_mem[base+4]}, 32'h47);
    base = log_n;
    rx_level = 7'd0;
    settle(10);
    chk("R3 go after mixed traffic", log_n - base, 2);
    chk_burst("R3 go chars mixed", base, 1'b0, 2'b10, 2'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule